// File: doc/BRIEF.md
# Multi-Width Serial Flash Protocol Front-End

This block is the target-side front end of a serial flash port. It watches chip select, the serial clock and four data lines, and it turns each framed transaction into a decoded instruction, a decoded address and a stream of read bytes shifted back to the host. One of three bus protocols is active at a time: extended (instruction on a single line, later phases on one, two or four lines chosen by the instruction), dual (every phase on two lines) or quad (every phase on four lines). The protocol lives in a volatile configuration register. That register loads a non-volatile default at reset and can be rewritten through a side port or through an in-band write-config instruction.

The block does not run the serial clock as a clock. It samples the serial clock, chip select and data lines on a faster system clock and finds the edges. Input bits are taken on rising serial-clock edges and output bits are launched on falling ones, which covers clock modes 0 and 3. An in-band escape returns the port to the extended protocol. The escape is exactly eight rising edges with DQ0 and DQ3 both high, followed by chip select rising. It is ignored while the execute-in-place flag is set.

The receive state machine has six states. ST_IDLE holds while chip select is high and latches the frame protocol. ST_CMD collects the instruction. ST_ADDR collects the address. ST_RDATA shifts read data out. ST_CFG collects the configuration byte. ST_SINK ignores the rest of the frame. The transitions are:
- ST_IDLE to ST_CMD when chip select is low.
- ST_CMD to ST_ADDR on a read instruction.
- ST_CMD to ST_CFG on the write-config instruction.
- ST_CMD to ST_SINK on any other instruction.
- ST_ADDR to ST_RDATA after the last address bit.
- ST_CFG to ST_SINK after the eighth data bit.
- Any state to ST_IDLE when chip select goes high.

Top module: `flash_link_front`

## Requirements
- R1: After reset, proto_o equals the non-volatile default (00, extended, by default), xip_o is 0, dq_oe is 0 and no strobe is raised.
- R2: The instruction is taken MSB first on rising serial-clock edges over 1 line (DQ0, 8 clocks), 2 lines ({DQ1,DQ0}, 4 clocks) or 4 lines ({DQ3..DQ0}, 2 clocks) for proto 00/01/10. cmd_valid then pulses with cmd_code.
- R3: A read takes a 24-bit address MSB first and pulses addr_valid with addr. In extended mode opcode 0x03 uses 1 line, 0x3C uses 2 and 0x6C uses 4. In dual and quad mode any of the three opcodes uses the protocol width.
- R4: Read bytes are launched MSB first on falling edges on the same width as the address: DQ1 alone, {DQ1,DQ0}, or {DQ3..DQ0}. The first byte is rd_data for rd_addr equal to the address, and rd_addr increments once per byte.
- R5: dq_oe is 0010, 0011 or 1111 (1, 2, 4 lines) only during the read data phase. It is 0 during instruction and address phases and one cycle after chip select rises.
- R6: A cfg_we pulse loads proto (cfg_proto) and the xip flag (cfg_xip). A proto value of 11 makes the whole write ignored.
- R7: Opcode 0x81 is followed by one byte on the instruction width. Bits [1:0] of that byte give the proto and bit 3 gives the xip flag. The byte applies after its eighth bit and is ignored entirely if bits [1:0] are 11.
- R8: Chip select rising before the last instruction bit raises no strobe and changes no configuration.
- R9: In dual or quad mode with xip 0, exactly 8 rising edges from chip select low, each with DQ0=DQ3=1, followed by chip select rising, set proto to 00 and leave xip unchanged.
- R10: 7 or 9 such edges, or any edge in the frame with DQ0 or DQ3 low, leave proto unchanged.
- R11: While xip is 1 the exit sequence leaves proto unchanged.
- R12: The protocol is latched at frame start, so a configuration change in mid-frame does not alter the widths of the frame in progress.
- R13: After an unknown opcode the rest of the frame raises no addr_valid and keeps dq_oe at 0.
- R14: Clock mode 3 (serial clock idle high) gives the same decoded results as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| dq_in | input | 4 | Data line input values |
| dq_out | output | 4 | Data line output values |
| dq_oe | output | 4 | Per-line output enable |
| cfg_we | input | 1 | Side-port configuration write strobe |
| cfg_proto | input | 2 | Protocol for the side-port write |
| cfg_xip | input | 1 | Execute-in-place flag for the side-port write |
| cmd_valid | output | 1 | Instruction received pulse |
| cmd_code | output | 8 | Received instruction |
| addr_valid | output | 1 | Address received pulse |
| addr | output | ADDR_W | Received address |
| rd_addr | output | ADDR_W | Address of the byte being fetched |
| rd_data | input | 8 | Byte at rd_addr from the array |
| proto_o | output | 2 | Active protocol |
| xip_o | output | 1 | Execute-in-place flag |

## Verification
The bench builds the block with ADDR_W=24, EXIT_CLKS=8 and the extended protocol as the reset default. Full 24-bit addresses therefore exercise all three lane widths and the escape counter at its real length. Starting in extended mode brings the per-opcode widths into reach before any configuration write. The dual and quad protocols, the reserved code and execute-in-place are then reached through both configuration paths, in clock modes 0 and 3.

// File: rtl/flash_link_pkg.sv
package flash_link_pkg;

    typedef enum logic [1:0] {
        PROTO_EXT  = 2'b00,
        PROTO_DUAL = 2'b01,
        PROTO_QUAD = 2'b10,
        PROTO_RSVD = 2'b11
    } proto_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_RDATA,
        ST_CFG,
        ST_SINK
    } fl_state_t;

    localparam logic [7:0] OP_READ_X1 = 8'h03;
    localparam logic [7:0] OP_READ_X2 = 8'h3C;
    localparam logic [7:0] OP_READ_X4 = 8'h6C;
    localparam logic [7:0] OP_CFG_WR  = 8'h81;

    // lanes used by the instruction phase
    function automatic logic [2:0] proto_lanes(proto_t p);
        case (p)
            PROTO_DUAL: return 3'd2;
            PROTO_QUAD: return 3'd4;
            default:    return 3'd1;
        endcase
    endfunction

    // lanes used by the phases that follow the instruction
    function automatic logic [2:0] data_lanes(proto_t p, logic [7:0] op);
        if (p != PROTO_EXT) return proto_lanes(p);
        case (op)
            OP_READ_X2: return 3'd2;
            OP_READ_X4: return 3'd4;
            default:    return 3'd1;
        endcase
    endfunction

    function automatic logic is_read(logic [7:0] op);
        return (op == OP_READ_X1) || (op == OP_READ_X2) || (op == OP_READ_X4);
    endfunction

    function automatic logic [3:0] oe_mask(logic [2:0] w);
        case (w)
            3'd4:    return 4'b1111;
            3'd2:    return 4'b0011;
            default: return 4'b0010;
        endcase
    endfunction

endpackage

// File: rtl/fl_edges.sv
module fl_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_end
);

    logic sclk_d;
    logic cs_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk;
            cs_d   <= cs_n;
        end
    end

    assign sclk_rise = !cs_n && sclk && !sclk_d;
    assign sclk_fall = !cs_n && !sclk && sclk_d;
    assign cs_end    = cs_n && !cs_d;

endmodule

// File: rtl/fl_cfg.sv
module fl_cfg
    import flash_link_pkg::*;
#(
    parameter proto_t RESET_PROTO = PROTO_EXT,
    parameter logic   RESET_XIP   = 1'b0,
    parameter int     EXIT_CLKS   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       cs_end,
    input  logic       sclk_rise,
    input  logic       line_a,
    input  logic       line_b,
    input  logic       port_we,
    input  logic [1:0] port_proto,
    input  logic       port_xip,
    input  logic       band_we,
    input  logic [1:0] band_proto,
    input  logic       band_xip,
    output proto_t     proto,
    output logic       xip
);

    localparam int CNT_W = $clog2(EXIT_CLKS + 2);
    localparam logic [CNT_W-1:0] CNT_TARGET = CNT_W'(EXIT_CLKS);
    localparam logic [CNT_W-1:0] CNT_MAX    = CNT_W'(EXIT_CLKS + 1);

    logic [CNT_W-1:0] ones_cnt;
    logic             ones_run;
    logic             exit_hit;

    // counts leading rising edges with both escape lines high
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            ones_cnt <= '0;
            ones_run <= 1'b1;
        end else if (sclk_rise) begin
            if (ones_run && line_a && line_b) begin
                if (ones_cnt != CNT_MAX) ones_cnt <= ones_cnt + 1'b1;
            end else begin
                ones_run <= 1'b0;
            end
        end
    end

    assign exit_hit = cs_end && ones_run && (ones_cnt == CNT_TARGET)
                      && (proto != PROTO_EXT) && !xip;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proto <= RESET_PROTO;
            xip   <= RESET_XIP;
        end else if (port_we && (port_proto != PROTO_RSVD)) begin
            proto <= proto_t'(port_proto);
            xip   <= port_xip;
        end else if (band_we && (band_proto != PROTO_RSVD)) begin
            proto <= proto_t'(band_proto);
            xip   <= band_xip;
        end else if (exit_hit) begin
            proto <= PROTO_EXT;
        end
    end

    assert_no_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        proto != PROTO_RSVD);

    assert_rsvd_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (port_we && port_proto == PROTO_RSVD && !band_we && !cs_end)
        |=> ($stable(proto) && $stable(xip)));

    assert_proto_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_we && !band_we && !cs_end) |=> $stable(proto));

    assert_xip_blocks_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (xip && !port_we && !band_we) |=> $stable(proto));

endmodule

// File: rtl/fl_rx.sv
module fl_rx
    import flash_link_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk_rise,
    input  logic [3:0]        dq_in,
    input  proto_t            proto,
    input  logic              fetch,
    output fl_state_t         state,
    output logic [2:0]        data_w,
    output logic              cmd_valid,
    output logic [7:0]        cmd_code,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              band_we,
    output logic [1:0]        band_proto,
    output logic              band_xip
);

    localparam int CNT_W = $clog2(ADDR_W + 1);
    localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(8);
    localparam logic [CNT_W-1:0] ADDR_BITS = CNT_W'(ADDR_W);

    fl_state_t         st_n;
    proto_t            frame_proto;
    logic [7:0]        op_q;
    logic [ADDR_W-1:0] sh;
    logic [ADDR_W-1:0] sh_n;
    logic [CNT_W-1:0]  bcnt;
    logic [CNT_W-1:0]  bcnt_n;
    logic [2:0]        in_w;
    logic              phase_done;

    assign data_w = data_lanes(frame_proto, op_q);

    always_comb begin
        in_w = (state == ST_CMD) ? proto_lanes(frame_proto) : data_w;
        case (in_w)
            3'd4:    sh_n = {sh[ADDR_W-5:0], dq_in};
            3'd2:    sh_n = {sh[ADDR_W-3:0], dq_in[1:0]};
            default: sh_n = {sh[ADDR_W-2:0], dq_in[0]};
        endcase
        bcnt_n     = bcnt + CNT_W'(in_w);
        phase_done = sclk_rise &&
                     (bcnt_n == ((state == ST_ADDR) ? ADDR_BITS : BYTE_BITS));
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= st_n;
    end

    // next-state logic
    always_comb begin
        st_n = state;
        if (cs_n) begin
            st_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  st_n = ST_CMD;
                ST_CMD: begin
                    if (phase_done) begin
                        if (is_read(sh_n[7:0]))          st_n = ST_ADDR;
                        else if (sh_n[7:0] == OP_CFG_WR) st_n = ST_CFG;
                        else                             st_n = ST_SINK;
                    end
                end
                ST_ADDR:  if (phase_done) st_n = ST_RDATA;
                ST_CFG:   if (phase_done) st_n = ST_SINK;
                ST_RDATA: st_n = ST_RDATA;
                ST_SINK:  st_n = ST_SINK;
                default:  st_n = ST_IDLE;
            endcase
        end
    end

    // datapath and strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_proto <= PROTO_EXT;
            op_q        <= '0;
            sh          <= '0;
            bcnt        <= '0;
            cmd_valid   <= 1'b0;
            cmd_code    <= '0;
            addr_valid  <= 1'b0;
            addr        <= '0;
            rd_addr     <= '0;
            band_we     <= 1'b0;
            band_proto  <= '0;
            band_xip    <= 1'b0;
        end else begin
            cmd_valid  <= 1'b0;
            addr_valid <= 1'b0;
            band_we    <= 1'b0;
            if (state == ST_IDLE) begin
                frame_proto <= proto;
                bcnt        <= '0;
            end else if (sclk_rise &&
                         (state == ST_CMD || state == ST_ADDR || state == ST_CFG)) begin
                sh   <= sh_n;
                bcnt <= phase_done ? '0 : bcnt_n;
            end
            if (phase_done) begin
                unique case (state)
                    ST_CMD: begin
                        cmd_valid <= 1'b1;
                        cmd_code  <= sh_n[7:0];
                        op_q      <= sh_n[7:0];
                    end
                    ST_ADDR: begin
                        addr_valid <= 1'b1;
                        addr       <= sh_n;
                        rd_addr    <= sh_n;
                    end
                    ST_CFG: begin
                        band_we    <= 1'b1;
                        band_proto <= sh_n[1:0];
                        band_xip   <= sh_n[3];
                    end
                    default: ;
                endcase
            end else if (state == ST_RDATA && fetch) begin
                rd_addr <= rd_addr + 1'b1;
            end
        end
    end

    assert_cmd_from_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($past(state) == ST_CMD));

    assert_addr_enters_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (state == ST_RDATA));

    assert_partial_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD && cs_n) |=> !cmd_valid);

endmodule

// File: rtl/fl_tx.sv
module fl_tx
    import flash_link_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk_fall,
    input  logic       active,
    input  logic [2:0] lanes,
    input  logic [7:0] rd_data,
    output logic [3:0] dq_out,
    output logic [3:0] dq_oe,
    output logic       fetch
);

    logic [7:0] out_sh;
    logic [3:0] out_left;
    logic [7:0] src;

    assign src = (out_left == 4'd0) ? rd_data : out_sh;

    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            dq_out   <= '0;
            dq_oe    <= '0;
            out_sh   <= '0;
            out_left <= '0;
            fetch    <= 1'b0;
        end else begin
            fetch <= 1'b0;
            if (active && sclk_fall) begin
                dq_oe    <= oe_mask(lanes);
                fetch    <= (out_left == 4'd0);
                out_left <= ((out_left == 4'd0) ? 4'd8 : out_left) - {1'b0, lanes};
                case (lanes)
                    3'd4: begin
                        dq_out <= src[7:4];
                        out_sh <= {src[3:0], 4'b0};
                    end
                    3'd2: begin
                        dq_out <= {2'b00, src[7:6]};
                        out_sh <= {src[5:0], 2'b0};
                    end
                    default: begin
                        dq_out <= {2'b00, src[7], 1'b0};
                        out_sh <= {src[6:0], 1'b0};
                    end
                endcase
            end
        end
    end

    assert_oe_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe != 4'b0000) |-> active);

    assert_oe_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe != 4'b0000) |-> ($countones(dq_oe) == int'(lanes)));

endmodule

// File: rtl/flash_link_front.sv
module flash_link_front
    import flash_link_pkg::*;
#(
    parameter int     ADDR_W      = 24,
    parameter int     EXIT_CLKS   = 8,
    parameter proto_t RESET_PROTO = PROTO_EXT,
    parameter logic   RESET_XIP   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [3:0]        dq_in,
    output logic [3:0]        dq_out,
    output logic [3:0]        dq_oe,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_proto,
    input  logic              cfg_xip,
    output logic              cmd_valid,
    output logic [7:0]        cmd_code,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic [1:0]        proto_o,
    output logic              xip_o
);

    logic      sclk_rise, sclk_fall, cs_end;
    logic      fetch;
    fl_state_t state;
    logic [2:0] data_w;
    logic      band_we;
    logic [1:0] band_proto;
    logic      band_xip;
    proto_t    proto;

    fl_edges u_edges (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_end(cs_end)
    );

    fl_cfg #(
        .RESET_PROTO(RESET_PROTO), .RESET_XIP(RESET_XIP), .EXIT_CLKS(EXIT_CLKS)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_end(cs_end),
        .sclk_rise(sclk_rise), .line_a(dq_in[0]), .line_b(dq_in[3]),
        .port_we(cfg_we), .port_proto(cfg_proto), .port_xip(cfg_xip),
        .band_we(band_we), .band_proto(band_proto), .band_xip(band_xip),
        .proto(proto), .xip(xip_o)
    );

    fl_rx #(.ADDR_W(ADDR_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_rise(sclk_rise),
        .dq_in(dq_in), .proto(proto), .fetch(fetch), .state(state),
        .data_w(data_w), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .addr_valid(addr_valid), .addr(addr), .rd_addr(rd_addr),
        .band_we(band_we), .band_proto(band_proto), .band_xip(band_xip)
    );

    fl_tx u_tx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_fall(sclk_fall),
        .active(state == ST_RDATA), .lanes(data_w), .rd_data(rd_data),
        .dq_out(dq_out), .dq_oe(dq_oe), .fetch(fetch)
    );

    assign proto_o = proto;

    assert_cs_clears_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (dq_oe == 4'b0000));

endmodule

// File: tb/sim_flash_link_front.sv
module sim_flash_link_front;

    localparam int AW = 24;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, cs_n, sclk;
    logic [3:0]    dq_in, dq_out, dq_oe;
    logic          cfg_we, cfg_xip;
    logic [1:0]    cfg_proto;
    logic          cmd_valid, addr_valid, xip_o;
    logic [7:0]    cmd_code, rd_data;
    logic [AW-1:0] addr, rd_addr;
    logic [1:0]    proto_o;

    int n_chk = 0, n_fail = 0, n_cmd = 0, n_addr = 0;
    logic [7:0]    last_cmd;
    logic [AW-1:0] last_addr;
    logic [3:0]    oe_acc;
    bit            done = 0;

    flash_link_front #(.ADDR_W(AW), .EXIT_CLKS(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .cfg_we(cfg_we), .cfg_proto(cfg_proto),
        .cfg_xip(cfg_xip), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .addr_valid(addr_valid), .addr(addr), .rd_addr(rd_addr),
        .rd_data(rd_data), .proto_o(proto_o), .xip_o(xip_o)
    );

    function automatic logic [7:0] exp_byte(logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction
    assign rd_data = exp_byte(rd_addr);

    function automatic logic [3:0] exp_oe(int w);
        return (w == 4) ? 4'b1111 : (w == 2) ? 4'b0011 : 4'b0010;
    endfunction

    always @(negedge clk) begin
        if (cmd_valid)  begin n_cmd++;  last_cmd  = cmd_code; end
        if (addr_valid) begin n_addr++; last_addr = addr;     end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic pulse(input logic [3:0] d, output logic [3:0] o, output logic [3:0] e);
        sclk = 1'b0; dq_in = d;
        repeat (2) @(negedge clk);
        o = dq_out; e = dq_oe;
        sclk = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int nbits, input int w);
        logic [3:0] o, e, d;
        for (int k = nbits - w; k >= 0; k -= w) begin
            d = 4'((v >> k) & ((32'd1 << w) - 1));
            pulse(d, o, e);
            oe_acc |= e;
        end
    endtask

    task automatic recv_byte(input int w, output logic [7:0] b, output logic [3:0] e);
        logic [3:0] o;
        b = '0;
        for (int k = 0; k < 8; k += w) begin
            pulse(4'h0, o, e);
            if (w == 4)      b = {b[3:0], o};
            else if (w == 2) b = {b[5:0], o[1:0]};
            else             b = {b[6:0], o[1]};
        end
    endtask

    task automatic frame_start(input bit m3);
        sclk = m3; cs_n = 1'b0; oe_acc = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic frame_end(input bit m3);
        if (!m3) begin sclk = 1'b0; repeat (2) @(negedge clk); end
        cs_n = 1'b1; dq_in = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] p, input logic x);
        cfg_we = 1'b1; cfg_proto = p; cfg_xip = x;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_read(input bit m3, input int pw, input int dw,
                           input logic [7:0] op, input logic [AW-1:0] a, input int nb);
        logic [7:0] b; logic [3:0] e;
        int c0 = n_cmd, a0 = n_addr;
        frame_start(m3);
        send_bits({24'd0, op}, 8, pw);
        chk("R2 cmd count", n_cmd - c0, 1);
        chk("R2 cmd code", last_cmd, op);
        send_bits({8'd0, a}, AW, dw);
        chk("R3 addr count", n_addr - a0, 1);
        chk("R3 addr", last_addr, a);
        chk("R5 oe before data", oe_acc, 0);
        for (int i = 0; i < nb; i++) begin
            recv_byte(dw, b, e);
            chk(m3 ? "R14 R4 byte" : "R4 byte", b, exp_byte(a + AW'(i)));
            chk("R5 oe mask", e, exp_oe(dw));
        end
        frame_end(m3);
        chk("R5 oe after cs", dq_oe, 0);
    endtask

    task automatic raw_frame(input int n, input logic [3:0] d, input int bad_at);
        logic [3:0] o, e;
        frame_start(1'b0);
        for (int i = 0; i < n; i++) pulse((i == bad_at) ? (d & 4'b0111) : d, o, e);
        frame_end(1'b0);
    endtask

    task automatic cfg_frame(input int pw, input logic [7:0] v);
        frame_start(1'b0);
        send_bits({24'd0, 8'h81}, 8, pw);
        send_bits({24'd0, v}, 8, pw);
        frame_end(1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] b; logic [3:0] e; logic [3:0] o;
        int c0, a0;
        void'($urandom(32'd7351));
        rst_n = 0; cs_n = 1; sclk = 0; dq_in = 0;
        cfg_we = 0; cfg_proto = 0; cfg_xip = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 proto", proto_o, 2'b00);
        chk("R1 xip", xip_o, 0);
        chk("R1 oe", dq_oe, 0);
        chk("R1 strobes", {cmd_valid, addr_valid}, 0);

        // R3 extended per-opcode widths
        do_read(0, 1, 1, 8'h03, 24'h123456, 3);
        do_read(0, 1, 2, 8'h3C, 24'hABCDEF, 2);
        do_read(1, 1, 4, 8'h6C, 24'hFFFFFE, 3);

        // R6 side port
        set_cfg(2'b01, 0);
        chk("R6 proto dual", proto_o, 2'b01);
        set_cfg(2'b11, 1);
        chk("R6 reserved proto", proto_o, 2'b01);
        chk("R6 reserved xip", xip_o, 0);
        do_read(0, 2, 2, 8'h03, 24'h00F0F0, 2);

        // R7 in-band config
        cfg_frame(2, 8'h02);
        chk("R7 inband quad", proto_o, 2'b10);
        cfg_frame(4, 8'h0B);
        chk("R7 inband reserved", {xip_o, proto_o}, 3'b010);
        do_read(1, 4, 4, 8'h03, 24'h5A5A00, 2);

        // R8 partial instruction, quad: 1 of 2 clocks
        c0 = n_cmd;
        frame_start(0); pulse(4'h8, o, e); frame_end(0);
        chk("R8 partial quad", n_cmd - c0, 0);
        chk("R8 cfg kept", proto_o, 2'b10);

        // R10 near misses of the escape
        raw_frame(7, 4'hF, -1);
        chk("R10 seven edges", proto_o, 2'b10);
        raw_frame(9, 4'hF, -1);
        chk("R10 nine edges", proto_o, 2'b10);
        raw_frame(8, 4'hF, 5);
        chk("R10 dq3 low once", proto_o, 2'b10);

        // R11 xip blocks escape
        set_cfg(2'b10, 1);
        raw_frame(8, 4'hF, -1);
        chk("R11 xip holds", proto_o, 2'b10);
        set_cfg(2'b10, 0);

        // R9 escape from quad and dual
        raw_frame(8, 4'hF, -1);
        chk("R9 quad exit", proto_o, 2'b00);
        chk("R9 xip kept", xip_o, 0);
        set_cfg(2'b01, 0);
        raw_frame(8, 4'h9, -1);
        chk("R9 dual exit", proto_o, 2'b00);

        // R8 partial instruction, extended: 7 of 8 clocks
        c0 = n_cmd;
        frame_start(0); send_bits(32'h7F, 7, 1); frame_end(0);
        chk("R8 partial ext", n_cmd - c0, 0);

        // R13 unknown opcode in quad
        set_cfg(2'b10, 0);
        a0 = n_addr;
        frame_start(0);
        send_bits(32'h55, 8, 4);
        send_bits(32'h123456, 24, 4);
        for (int i = 0; i < 4; i++) begin pulse(4'h0, o, e); oe_acc |= e; end
        frame_end(0);
        chk("R13 no addr", n_addr - a0, 0);
        chk("R13 no oe", oe_acc, 0);

        // R12 mid-frame change keeps quad widths
        frame_start(0);
        send_bits(32'h03, 8, 4);
        send_bits(32'h0000C3, 24, 4);
        cfg_we = 1; cfg_proto = 2'b00; cfg_xip = 0;
        @(negedge clk); cfg_we = 0;
        for (int i = 0; i < 2; i++) begin
            recv_byte(4, b, e);
            chk("R12 byte", b, exp_byte(24'h0000C3 + 24'(i)));
            chk("R12 oe", e, 4'b1111);
        end
        frame_end(0);
        chk("R12 cfg applied", proto_o, 2'b00);

        // random reads over all protocols and opcodes
        for (int it = 0; it < 40; it++) begin
            int p, pw, dw, nb; logic [7:0] op; logic [AW-1:0] a; bit m3;
            p  = int'($urandom % 3);
            set_cfg(2'(p), 0);
            case ($urandom % 3)
                0: op = 8'h03;
                1: op = 8'h3C;
                default: op = 8'h6C;
            endcase
            pw = (p == 0) ? 1 : (p == 1) ? 2 : 4;
            dw = (p != 0) ? pw : (op == 8'h3C) ? 2 : (op == 8'h6C) ? 4 : 1;
            a  = AW'($urandom);
            m3 = bit'($urandom % 2);
            nb = 1 + int'($urandom % 3);
            do_read(m3, pw, dw, op, a, nb);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule